// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block holds a bank of byte-wide chipset configuration registers that software reaches through two I/O ports: an index port selects an entry and a data port reads or writes it. The index takes only values from a fixed window, and after any completed data-port access it drops back to zero. Software must therefore rewrite the index before every data access. Two independent scratch bytes sit at their own I/O addresses.

The whole register array is brought out on a flat output bus for the chipset logic that uses it. Each accepted data write also raises a one-cycle event. The event carries the register index and a mask of the bits that changed, so that consumers act only on real transitions. Two of the reset defaults come from board inputs: a memory-size code and a slow-CPU strap.

Top module: `chipset_cfg_regs`

## Requirements
- R1: During reset the index becomes 0x00 and both scratch bytes become 0xFF. Every entry becomes 0x00, with these exceptions: 0x61=0x09, 0x62=0xFF, 0x6F=0x20, 0x73=0xF0, 0x76=0x01, 0x59={2'b01, mem_size_code[5:0]}, and 0x58={slow_strap, 7'b0}. Entry k appears on `cfg_regs[(k-0x50)*8 +: 8]`.
- R2: A write to port 0x22 loads the index only if the value lies from 0x50 to 0x76 inclusive. Any other value leaves the index unchanged.
- R3: A write to port 0x23 while the index is valid stores the byte in that entry and then clears the index to 0x00. While the index is invalid, the write changes no entry and leaves the index unchanged.
- R4: A read of port 0x23 while the index is valid returns the entry and clears the index to 0x00. While the index is invalid, the read returns 0xFF and leaves the index unchanged.
- R5: A data-port read of entry 0x58 always returns bit 3 as 0. The stored bit is not changed.
- R6: The cycle after an accepted data write, `evt_valid` is high for one cycle. In that cycle `evt_index` holds the written index and `evt_xor` holds the old value XOR the new value. Scratch writes and rejected writes raise no event.
- R7: Ports 0xE1 and 0xE2 are independent scratch bytes. Each reads back the last value written to it, and accessing them changes neither the index nor the entries.
- R8: An access to any other address is not claimed (`io_claim` low), reads as 0xFF and changes no state. A claimed read returns data in the same cycle as `io_rd`.
- R9: A read of port 0x22 returns the current index and does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_size_code | input | 6 | Memory-size code loaded into entry 0x59 at reset |
| slow_strap | input | 1 | Slow-CPU strap loaded into entry 0x58 bit 7 at reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access (ignored when io_wr is high) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not claimed |
| io_claim | output | 1 | Access addresses a decoded port |
| evt_valid | output | 1 | One-cycle pulse after an accepted data write |
| evt_index | output | 8 | Index of the written entry |
| evt_xor | output | 8 | Changed-bit mask of the write |
| cfg_regs | output | 312 | All entries, entry 0x50 in the low byte |

## Verification
The change event of a data write is still on its outputs in the next cycle. If software writes a new index in that same cycle, the pulse and the index update overlap. The bench provokes this by issuing an index-port write immediately after a data write. It checks that the event still reports the previous index and changed-bit mask while the access is claimed. It then confirms that the event has dropped and that reading the index port returns the newly accepted value.

// File: rtl/chipset_cfg_regs.sv
module chipset_cfg_regs #(
  parameter int             ADDR_W    = 16,
  parameter logic [15:0]    IDX_PORT  = 16'h0022,
  parameter logic [15:0]    DATA_PORT = 16'h0023,
  parameter logic [15:0]    SCR0_PORT = 16'h00E1,
  parameter logic [15:0]    SCR1_PORT = 16'h00E2,
  parameter logic [7:0]     IDX_LO    = 8'h50,
  parameter logic [7:0]     IDX_HI    = 8'h76,
  parameter logic [7:0]     MASK_IDX  = 8'h58,
  parameter logic [7:0]     MASK_BITS = 8'h08,
  parameter int             NREG      = int'(IDX_HI) - int'(IDX_LO) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        mem_size_code,
  input  logic              slow_strap,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_claim,
  output logic              evt_valid,
  output logic [7:0]        evt_index,
  output logic [7:0]        evt_xor,
  output logic [NREG*8-1:0] cfg_regs
);
  localparam int OFF_W = $clog2(NREG);

  logic [7:0] regs [NREG];
  logic [7:0] cur_idx;
  logic [7:0] scr0, scr1;

  wire hit_idx  = io_addr == ADDR_W'(IDX_PORT);
  wire hit_data = io_addr == ADDR_W'(DATA_PORT);
  wire hit_s0   = io_addr == ADDR_W'(SCR0_PORT);
  wire hit_s1   = io_addr == ADDR_W'(SCR1_PORT);
  wire decoded  = hit_idx | hit_data | hit_s0 | hit_s1;
  wire rd_go    = io_rd & ~io_wr;

  wire in_win_wd  = (io_wdata >= IDX_LO) && (io_wdata <= IDX_HI);
  wire idx_ok     = (cur_idx >= IDX_LO) && (cur_idx <= IDX_HI);
  wire [7:0] off8 = cur_idx - IDX_LO;
  wire [OFF_W-1:0] off = idx_ok ? off8[OFF_W-1:0] : '0;
  wire [7:0] cur_val = regs[off];

  wire wr_idx  = io_wr & hit_idx & in_win_wd;
  wire wr_data = io_wr & hit_data & idx_ok;
  wire rd_data = rd_go & hit_data & idx_ok;

  function automatic logic [7:0] dflt(input int i, input logic strap, input logic [5:0] code);
    logic [7:0] a;
    a = IDX_LO + 8'(i);
    case (a)
      8'h58:   dflt = {strap, 7'b0};
      8'h59:   dflt = {2'b01, code};
      8'h61:   dflt = 8'h09;
      8'h62:   dflt = 8'hFF;
      8'h6F:   dflt = 8'h20;
      8'h73:   dflt = 8'hF0;
      8'h76:   dflt = 8'h01;
      default: dflt = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i, slow_strap, mem_size_code);
      cur_idx   <= '0;
      scr0      <= 8'hFF;
      scr1      <= 8'hFF;
      evt_valid <= 1'b0;
      evt_index <= '0;
      evt_xor   <= '0;
    end else begin
      evt_valid <= wr_data;
      if (wr_data) begin
        regs[off] <= io_wdata;
        evt_index <= cur_idx;
        evt_xor   <= cur_val ^ io_wdata;
      end
      if (wr_idx)                cur_idx <= io_wdata;
      else if (wr_data | rd_data) cur_idx <= '0;
      if (io_wr & hit_s0) scr0 <= io_wdata;
      if (io_wr & hit_s1) scr1 <= io_wdata;
    end
  end

  wire [7:0] data_rd = !idx_ok ? 8'hFF :
                       (cur_idx == MASK_IDX) ? (cur_val & ~MASK_BITS) : cur_val;

  always_comb begin
    io_rdata = 8'hFF;
    if (rd_go) begin
      if (hit_idx)       io_rdata = cur_idx;
      else if (hit_data) io_rdata = data_rd;
      else if (hit_s0)   io_rdata = scr0;
      else if (hit_s1)   io_rdata = scr1;
    end
  end

  assign io_claim = (io_wr | io_rd) & decoded;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_regs[g*8 +: 8] = regs[g];
  end

  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == 8'h00) || idx_ok); // R2
  AST_IDX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_data | rd_data) && !wr_idx) |=> (cur_idx == 8'h00)); // R3
  AST_BAD_DATA_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_data && !idx_ok) |=> $stable(cur_idx)); // R3
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R6
  AST_EVT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (evt_valid && evt_index == $past(cur_idx))); // R6
  AST_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && hit_data && cur_idx == MASK_IDX) |-> ((io_rdata & MASK_BITS) == 8'h00)); // R5
  AST_UNCLAIMED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !io_claim |-> (io_rdata == 8'hFF)); // R8
endmodule

// File: tb/test_chipset_cfg_regs.sv
module test_chipset_cfg_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] mem_size_code = 6'h13;
  logic slow_strap = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata;
  logic io_claim, evt_valid;
  logic [7:0] evt_index, evt_xor;
  logic [311:0] cfg_regs;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chipset_cfg_regs i_chipset_cfg_regs (
    .clk, .rst_n, .mem_size_code, .slow_strap, .io_addr, .io_wr, .io_rd,
    .io_wdata, .io_rdata, .io_claim, .evt_valid, .evt_index, .evt_xor, .cfg_regs);

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] d, output logic cl);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2; d = io_rdata; cl = io_claim;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  function automatic logic [7:0] entry(input logic [7:0] idx);
    return cfg_regs[(int'(idx) - 8'h50)*8 +: 8];
  endfunction

  // {req[3:0], op (1=read), addr[15:0], data/expected[7:0]}
  localparam int NV = 44;
  localparam logic [28:0] VEC [NV] = '{
    {4'd9, 1'b1, 16'h0022, 8'h00},  // R9 reset index
    {4'd2, 1'b0, 16'h0022, 8'h61},
    {4'd4, 1'b1, 16'h0023, 8'h09},  // R4 valid read
    {4'd4, 1'b1, 16'h0022, 8'h00},  // R4 cleared
    {4'd2, 1'b0, 16'h0022, 8'h4F},
    {4'd2, 1'b1, 16'h0022, 8'h00},  // R2 below window
    {4'd2, 1'b0, 16'h0022, 8'h77},
    {4'd2, 1'b1, 16'h0022, 8'h00},  // R2 above window
    {4'd2, 1'b0, 16'h0022, 8'h76},
    {4'd9, 1'b1, 16'h0022, 8'h76},  // R9 no clear
    {4'd9, 1'b1, 16'h0022, 8'h76},
    {4'd1, 1'b1, 16'h0023, 8'h01},  // R1 top entry
    {4'd2, 1'b0, 16'h0022, 8'h65},
    {4'd2, 1'b0, 16'h0022, 8'h10},
    {4'd2, 1'b1, 16'h0022, 8'h65},  // R2 kept old
    {4'd1, 1'b1, 16'h0023, 8'h00},
    {4'd4, 1'b1, 16'h0023, 8'hFF},  // R4 invalid read
    {4'd4, 1'b1, 16'h0022, 8'h00},
    {4'd2, 1'b0, 16'h0022, 8'h50},
    {4'd3, 1'b0, 16'h0023, 8'hA5},
    {4'd3, 1'b1, 16'h0022, 8'h00},  // R3 cleared
    {4'd2, 1'b0, 16'h0022, 8'h50},
    {4'd3, 1'b1, 16'h0023, 8'hA5},  // R3 stored
    {4'd2, 1'b0, 16'h0022, 8'h58},
    {4'd1, 1'b1, 16'h0023, 8'h80},  // R1 strap
    {4'd2, 1'b0, 16'h0022, 8'h58},
    {4'd3, 1'b0, 16'h0023, 8'hFF},
    {4'd2, 1'b0, 16'h0022, 8'h58},
    {4'd5, 1'b1, 16'h0023, 8'hF7},  // R5 masked
    {4'd2, 1'b0, 16'h0022, 8'h59},
    {4'd1, 1'b1, 16'h0023, 8'h53},  // R1 memory code
    {4'd2, 1'b0, 16'h0022, 8'h6F},
    {4'd1, 1'b1, 16'h0023, 8'h20},
    {4'd2, 1'b0, 16'h0022, 8'h73},
    {4'd1, 1'b1, 16'h0023, 8'hF0},
    {4'd7, 1'b1, 16'h00E1, 8'hFF},  // R7 scratch reset
    {4'd7, 1'b0, 16'h00E1, 8'h3C},
    {4'd7, 1'b1, 16'h00E2, 8'hFF},
    {4'd7, 1'b0, 16'h00E2, 8'hC3},
    {4'd7, 1'b1, 16'h00E1, 8'h3C},  // R7 readback
    {4'd7, 1'b1, 16'h00E2, 8'hC3},
    {4'd8, 1'b0, 16'h0024, 8'h5A},
    {4'd8, 1'b1, 16'h0024, 8'hFF},  // R8 undecoded
    {4'd8, 1'b1, 16'h0020, 8'hFF}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
      end
    end
  end

  initial begin
    logic [7:0] d;
    logic cl;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset image on the register output
    for (int k = 8'h50; k <= 8'h76; k++) begin
      logic [7:0] e;
      case (k)
        8'h58: e = 8'h80; 8'h59: e = 8'h53; 8'h61: e = 8'h09; 8'h62: e = 8'hFF;
        8'h6F: e = 8'h20; 8'h73: e = 8'hF0; 8'h76: e = 8'h01; default: e = 8'h00;
      endcase
      check(1, entry(8'(k)), e, $sformatf("reset entry %02h", k));
    end

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        do_rd(VEC[v][23:8], d, cl);
        check(int'(VEC[v][28:25]), d, VEC[v][7:0], $sformatf("vector %0d read %04h", v, VEC[v][23:8]));
      end else do_wr(VEC[v][23:8], VEC[v][7:0]);
    end

    // R5 stored bit remains set
    check(5, entry(8'h58), 8'hFF, "entry 58 stored");
    // R8 claim flags
    do_rd(16'h0024, d, cl); check(8, {7'b0, cl}, 8'h00, "claim undecoded");
    do_rd(16'h00E2, d, cl); check(8, {7'b0, cl}, 8'h01, "claim scratch");
    check(8, entry(8'h50), 8'hA5, "undecoded write no effect");
    // R3 write with invalid index changes nothing
    do_wr(16'h0023, 8'h11);
    check(3, evt_valid, 8'h00 == 8'h00 ? 1'b0 : 1'b1, "no event on rejected write");
    check(3, entry(8'h50), 8'hA5, "rejected write entry");
    do_rd(16'h0022, d, cl); check(3, d, 8'h00, "rejected write index");
    // R7 scratch access left index alone
    do_wr(16'h0022, 8'h60);
    do_wr(16'h00E1, 8'h77);
    check(6, {7'b0, evt_valid}, 8'h00, "no event on scratch write");
    do_rd(16'h0022, d, cl); check(7, d, 8'h60, "index after scratch");

    // R6 event contents
    do_wr(16'h0023, 8'h3C);
    check(6, {7'b0, evt_valid}, 8'h01, "evt_valid");
    check(6, evt_index, 8'h60, "evt_index");
    check(6, evt_xor, 8'h3C, "evt_xor");
    @(posedge clk); #1;
    check(6, {7'b0, evt_valid}, 8'h00, "evt one cycle");

    // Overlap: index write while the event of the previous data write is out
    do_wr(16'h0022, 8'h60);
    do_wr(16'h0023, 8'h35);
    @(negedge clk);
    io_addr = 16'h0022; io_wdata = 8'h66; io_wr = 1'b1;
    #2;
    check(6, {7'b0, evt_valid}, 8'h01, "overlap evt_valid");
    check(6, evt_index, 8'h60, "overlap evt_index");
    check(6, evt_xor, 8'h09, "overlap evt_xor");
    check(8, {7'b0, io_claim}, 8'h01, "overlap claim");
    @(posedge clk); #1; io_wr = 1'b0;
    check(6, {7'b0, evt_valid}, 8'h00, "overlap evt drop");
    do_rd(16'h0022, d, cl); check(2, d, 8'h66, "overlap new index");

    // R1 second reset with other straps
    @(negedge clk);
    slow_strap = 1'b0; mem_size_code = 6'h24; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    check(1, entry(8'h58), 8'h00, "strap low");
    check(1, entry(8'h59), 8'h64, "memory code 24");
    check(1, entry(8'h50), 8'h00, "entry cleared");
    do_rd(16'h00E1, d, cl); check(1, d, 8'hFF, "scratch reset");
    do_rd(16'h0022, d, cl); check(1, d, 8'h00, "index reset");

    summary();
  end
endmodule